// File: doc/BRIEF.md
# Programmable External Chip Select Unit

This block turns a 32-bit bus address into one of seven active-low select strobes for external memories and peripherals. Each select has its own base address, block-size mask and control word. A compare on the upper sixteen address bits lets one region cover anything from 64 Kbytes to the whole 4-Gbyte space. For each matching access the block drives the select, an output enable on reads, four byte-lane strobes and a one-cycle transfer-done pulse. The access ends after a programmed number of wait states, or when an external acknowledge arrives.

Software programs the regions through a simple write port. After reset only select 0 is live. It covers the whole address space so that a boot device can be fetched from it, and its port width is taken from two configuration pins sampled during reset. The state machine runs on the rising clock edge. All bus-facing outputs are re-registered on the falling edge, so a select opens half a cycle after the start is seen.

Top module: `chip_select_unit`

## Requirements
- R1: The seven select outputs `cs_n[6:0]` are active low and never more than one is low at a time. Select i matches when its valid bit is set and `(bus_addr[31:16] & ~mask[31:16]) == (base[31:16] & ~mask[31:16])`.
- R2: When several selects match, the lowest-numbered one is driven.
- R3: After reset only select 0 is valid, with base 0 and mask all ones, so it matches every address. Selects 1 to 6 are invalid and match nothing until programmed.
- R4: On every clock edge while `rst_n` is low, select 0's port size is loaded from `boot_port_pins` if `boot_cfg_en` is high, and set to 32-bit otherwise. The value captured before reset ends is kept when the pins change afterwards.
- R5: After reset, select 0 uses internal termination with 15 wait states and byte-enable mode 0.
- R6: `bus_start` is sampled on a rising edge. Select, `oe_n` and `bs_n` change on the following falling edge, and go back to idle on the falling edge that follows the rising edge at which `xfer_done` rises.
- R7: With internal termination (control bit 6 = 1) and wait count W (control bits 5:2), `xfer_done` is high for exactly one cycle, starting at the rising edge W+1 cycles after the start edge.
- R8: With control bit 6 = 0, the access holds until `bus_ta_n` is sampled low on a rising edge after the start edge. `xfer_done` is high for the following cycle.
- R9: `oe_n` is low only while a read access is in progress to a matching select.
- R10: Port size is held in control bits 1:0 (00 or 11 = 32-bit, 01 = 8-bit, 10 = 16-bit). Transfer size `bus_size` uses 01 = byte, 10 = word, and 00 or 11 = long. Byte lane 3 (`bs_n[3]`) carries address offset 0. The lanes driven are:
  - 32-bit port: a byte at offset k drives lane 3-k; a word drives lanes 3:2 when A1 = 0 and lanes 1:0 when A1 = 1; a long drives all four lanes.
  - 16-bit port: a byte drives lane 3 when A0 = 0 and lane 2 when A0 = 1; a word or long drives lanes 3:2.
  - 8-bit port: lane 3 only.
- R11: Control bit 7 is the byte-enable mode. When it is 1, strobes are driven on reads and writes. When it is 0, they are driven on writes only, and `bs_n` stays high during reads.
- R12: The register write port works as follows:
  - `reg_kind` 00 loads base bits 31:16, 01 loads mask bits 31:16 and the valid bit (bit 0), and 10 loads the control bits 7:0.
  - `reg_sel` picks the select.
  - A write with `reg_sel` = 7 or `reg_kind` = 11 changes nothing.
- R13: An access that matches no select drives no select, no output enable, no strobe and no `xfer_done`. A `bus_start` during an access in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_cfg_en | input | 1 | Enables boot port-size capture during reset |
| boot_port_pins | input | 2 | Boot port-size code sampled during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Select index for the write |
| reg_kind | input | 2 | Register kind: base, mask/valid, control |
| reg_wdata | input | 32 | Write data |
| bus_start | input | 1 | Transfer start, one cycle |
| bus_addr | input | 32 | Transfer address |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_size | input | 2 | Transfer size code |
| bus_ta_n | input | 1 | External acknowledge, active low |
| cs_n | output | 7 | Select outputs, active low |
| oe_n | output | 1 | Output enable, active low |
| bs_n | output | 4 | Byte-lane strobes, active low |
| xfer_done | output | 1 | Transfer-done pulse |

## Verification
Each register field has a distinct symptom at the ports:
- A wrong base, mask or valid bit drives the wrong select, or none, half a cycle after the start edge.
- A stale port-size or byte-mode bit changes the `bs_n` pattern at that same falling edge.
- A wrong wait count, or a wrong termination choice, moves the `xfer_done` pulse and the select release by whole cycles.

A stuck access state would leave a select low and block every later start. Random region layouts with constrained addresses, mixed with directed overlap, boot and ignored-write cases, bring each of these to the ports within a few cycles.

// File: rtl/cs_pkg.sv
package cs_pkg;

   localparam int CS_WS_W = 4;

   typedef enum logic [1:0] {
      PS_32A = 2'b00,
      PS_8   = 2'b01,
      PS_16  = 2'b10,
      PS_32B = 2'b11
   } port_size_e;

   typedef enum logic [1:0] {
      SZ_LONG = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_WORD = 2'b10,
      SZ_LINE = 2'b11
   } xfer_size_e;

   typedef enum logic [1:0] {
      RK_BASE = 2'b00,
      RK_MASK = 2'b01,
      RK_CTRL = 2'b10,
      RK_NONE = 2'b11
   } reg_kind_e;

   // bit 7 byte mode, bit 6 internal termination, bits 5:2 waits, bits 1:0 port
   typedef struct packed {
      logic                 bem;
      logic                 aa;
      logic [CS_WS_W-1:0]   ws;
      port_size_e           ps;
   } cs_ctrl_t;

   localparam int CS_CTRL_W = $bits(cs_ctrl_t);

   // lanes for a four-lane bus, lane 3 = offset 0
   function automatic logic [3:0] lane_map(port_size_e ps, xfer_size_e sz,
                                           logic [1:0] a);
      logic [3:0] m;
      case (ps)
         PS_8:    m = 4'b1000;
         PS_16:   m = (sz == SZ_BYTE) ? (a[0] ? 4'b0100 : 4'b1000) : 4'b1100;
         default: begin
            case (sz)
               SZ_BYTE: m = 4'b1000 >> a;
               SZ_WORD: m = a[1] ? 4'b0011 : 4'b1100;
               default: m = 4'b1111;
            endcase
         end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cs_region.sv
module cs_region
   import cs_pkg::*;
#(
   parameter int IDX     = 0,
   parameter int ADDR_W  = 32,
   parameter int MASK_LSB = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       boot_cfg_en,
   input  logic [1:0]                 boot_port_pins,
   input  logic                       wr_en,
   input  reg_kind_e                  kind,
   input  logic [ADDR_W-1:0]          wdata,
   input  logic [ADDR_W-MASK_LSB-1:0] addr_hi,
   output logic                       hit,
   output cs_ctrl_t                   ctrl
);
   localparam int HW = ADDR_W - MASK_LSB;
   localparam bit IS_BOOT = (IDX == 0);

   logic [HW-1:0] base_q, mask_q;
   logic          valid_q;
   cs_ctrl_t      ctrl_q, ctrl_rst;
   logic          unused_wbits;

   assign unused_wbits = ^wdata[MASK_LSB-1:CS_CTRL_W];

   generate
      if (IS_BOOT) begin : g_boot
         always_comb begin
            ctrl_rst.bem = 1'b0;
            ctrl_rst.aa  = 1'b1;
            ctrl_rst.ws  = '1;
            ctrl_rst.ps  = boot_cfg_en ? port_size_e'(boot_port_pins) : PS_32A;
         end
      end else begin : g_plain
         logic unused_boot;
         assign unused_boot = boot_cfg_en ^ (^boot_port_pins);
         assign ctrl_rst = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         mask_q  <= '1;
         valid_q <= IS_BOOT;
         ctrl_q  <= ctrl_rst;
      end else if (wr_en) begin
         case (kind)
            RK_BASE: base_q <= wdata[ADDR_W-1:MASK_LSB];
            RK_MASK: begin
               mask_q  <= wdata[ADDR_W-1:MASK_LSB];
               valid_q <= wdata[0];
            end
            RK_CTRL: ctrl_q <= cs_ctrl_t'(wdata[CS_CTRL_W-1:0]);
            default: ;
         endcase
      end
   end

   assign hit  = valid_q && ((addr_hi & ~mask_q) == (base_q & ~mask_q));
   assign ctrl = ctrl_q;

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   output logic         any,
   output logic [N-1:0] pick
);
   assign any  = |hit;
   assign pick = hit & (~hit + N'(1));

   // R2
   prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ($onehot(pick) && ((pick & hit) == pick) && (((pick - N'(1)) & hit) == '0)));

endmodule

// File: rtl/cs_lane_dec.sv
module cs_lane_dec
   import cs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  port_size_e            ps,
   input  xfer_size_e            sz,
   input  logic [1:0]            a_lo,
   input  logic                  rd,
   input  logic                  bem,
   output logic [DATA_W/8-1:0]   lanes
);
   localparam int NL = DATA_W / 8;

   generate
      if (NL != 4) begin : g_bad
         $error("cs_lane_dec supports a four-lane bus only");
      end
   endgenerate

   // reads carry strobes only in byte-enable mode 1
   assign lanes = (rd && !bem) ? '0 : lane_map(ps, sz, a_lo);

endmodule

// File: rtl/cs_access_fsm.sv
module cs_access_fsm
   import cs_pkg::*;
#(
   parameter int N  = 7,
   parameter int NL = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          any,
   input  logic [N-1:0]  pick,
   input  cs_ctrl_t      ctrl,
   input  logic          rd,
   input  logic [NL-1:0] lanes,
   input  logic          ta_n,
   output logic [N-1:0]  cs_n,
   output logic          oe_n,
   output logic [NL-1:0] bs_n,
   output logic          done
);
   logic               busy, aa_q, rd_q, done_q;
   logic [CS_WS_W-1:0] cnt;
   logic [N-1:0]       sel_q;
   logic [NL-1:0]      lanes_q;
   logic               finish;

   assign finish = aa_q ? (cnt == '0) : !ta_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         aa_q    <= 1'b0;
         rd_q    <= 1'b0;
         done_q  <= 1'b0;
         cnt     <= '0;
         sel_q   <= '0;
         lanes_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy) begin
            if (finish) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end else if (aa_q) begin
               cnt <= cnt - 1'b1;
            end
         end else if (start && any) begin
            busy    <= 1'b1;
            cnt     <= ctrl.ws;
            aa_q    <= ctrl.aa;
            rd_q    <= rd;
            sel_q   <= pick;
            lanes_q <= lanes;
         end
      end
   end

   // bus-facing outputs move on the falling edge
   always_ff @(negedge clk) begin
      if (!rst_n) begin
         cs_n <= '1;
         oe_n <= 1'b1;
         bs_n <= '1;
      end else begin
         cs_n <= busy ? ~sel_q : '1;
         oe_n <= !(busy && rd_q);
         bs_n <= busy ? ~lanes_q : '1;
      end
   end

   assign done = done_q;

   // R1
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R9
   oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (cs_n != '1));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && aa_q && cnt != '0) |=> busy);

   // R8
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !aa_q && ta_n) |=> (busy && !done_q));

endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
   import cs_pkg::*;
#(
   parameter int NUM_SEL  = 7,
   parameter int SEL_W    = 3,
   parameter int ADDR_W   = 32,
   parameter int MASK_LSB = 16,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                boot_cfg_en,
   input  logic [1:0]          boot_port_pins,
   input  logic                reg_wr,
   input  logic [SEL_W-1:0]    reg_sel,
   input  logic [1:0]          reg_kind,
   input  logic [ADDR_W-1:0]   reg_wdata,
   input  logic                bus_start,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_read,
   input  logic [1:0]          bus_size,
   input  logic                bus_ta_n,
   output logic [NUM_SEL-1:0]  cs_n,
   output logic                oe_n,
   output logic [DATA_W/8-1:0] bs_n,
   output logic                xfer_done
);
   localparam int NL = DATA_W / 8;
   localparam int HW = ADDR_W - MASK_LSB;

   generate
      if (NUM_SEL < 1 || NUM_SEL > (1 << SEL_W)) begin : g_bad_n
         $error("NUM_SEL does not fit SEL_W");
      end
      if (MASK_LSB <= CS_CTRL_W || MASK_LSB >= ADDR_W) begin : g_bad_m
         $error("MASK_LSB out of range");
      end
   endgenerate

   logic [NUM_SEL-1:0] hit, pick;
   cs_ctrl_t           ctrl_v [NUM_SEL];
   cs_ctrl_t           ctrl_sel;
   logic               any;
   logic [NL-1:0]      lanes;
   logic               unused_addr;

   assign unused_addr = ^bus_addr[MASK_LSB-1:2];

   genvar g;
   generate
      for (g = 0; g < NUM_SEL; g++) begin : g_reg
         cs_region #(.IDX(g), .ADDR_W(ADDR_W), .MASK_LSB(MASK_LSB)) u_region (
            .clk            (clk),
            .rst_n          (rst_n),
            .boot_cfg_en    (boot_cfg_en),
            .boot_port_pins (boot_port_pins),
            .wr_en          (reg_wr && (reg_sel == SEL_W'(g))),
            .kind           (reg_kind_e'(reg_kind)),
            .wdata          (reg_wdata),
            .addr_hi        (bus_addr[ADDR_W-1:ADDR_W-HW]),
            .hit            (hit[g]),
            .ctrl           (ctrl_v[g])
         );
      end
   endgenerate

   cs_prio_pick #(.N(NUM_SEL)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .any   (any),
      .pick  (pick)
   );

   always_comb begin
      ctrl_sel = '0;
      for (int i = 0; i < NUM_SEL; i++)
         if (pick[i]) ctrl_sel = ctrl_v[i];
   end

   cs_lane_dec #(.DATA_W(DATA_W)) u_lanes (
      .ps    (ctrl_sel.ps),
      .sz    (xfer_size_e'(bus_size)),
      .a_lo  (bus_addr[1:0]),
      .rd    (bus_read),
      .bem   (ctrl_sel.bem),
      .lanes (lanes)
   );

   cs_access_fsm #(.N(NUM_SEL), .NL(NL)) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bus_start),
      .any   (any),
      .pick  (pick),
      .ctrl  (ctrl_sel),
      .rd    (bus_read),
      .lanes (lanes),
      .ta_n  (bus_ta_n),
      .cs_n  (cs_n),
      .oe_n  (oe_n),
      .bs_n  (bs_n),
      .done  (xfer_done)
   );

   // R13
   no_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n == '1) |-> (oe_n && (bs_n == '1)));

endmodule

// File: tb/tb_chip_select_unit.sv
module tb_chip_select_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_cfg_en = 1'b0;
   logic [1:0]  boot_port_pins = 2'b00;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [1:0]  reg_kind = '0;
   logic [31:0] reg_wdata = '0;
   logic        bus_start = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_read = 1'b0;
   logic [1:0]  bus_size = '0;
   logic        bus_ta_n = 1'b1;
   logic [6:0]  cs_n;
   logic        oe_n;
   logic [3:0]  bs_n;
   logic        xfer_done;

   int checks = 0;
   int failures = 0;

   logic [15:0] sh_base [7];
   logic [15:0] sh_mask [7];
   logic        sh_valid [7];
   logic [7:0]  sh_ctrl [7];

   chip_select_unit dut (
      .clk(clk), .rst_n(rst_n), .boot_cfg_en(boot_cfg_en),
      .boot_port_pins(boot_port_pins), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_kind(reg_kind), .reg_wdata(reg_wdata), .bus_start(bus_start),
      .bus_addr(bus_addr), .bus_read(bus_read), .bus_size(bus_size),
      .bus_ta_n(bus_ta_n), .cs_n(cs_n), .oe_n(oe_n), .bs_n(bs_n),
      .xfer_done(xfer_done)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit cfg, input logic [1:0] pins);
      @(negedge clk);
      rst_n = 1'b0; boot_cfg_en = cfg; boot_port_pins = pins;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 7; i++) begin
         sh_base[i] = '0; sh_mask[i] = 16'hFFFF; sh_valid[i] = (i == 0);
         sh_ctrl[i] = (i == 0) ? {1'b0, 1'b1, 4'hF, (cfg ? pins : 2'b00)} : 8'h00;
      end
      @(negedge clk);
      boot_port_pins = ~pins;   // R4: later pin changes must not matter
   endtask

   task automatic wreg(input logic [2:0] s, input logic [1:0] k, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_kind = k; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (s < 3'd7) begin
         case (k)
            2'b00: sh_base[s] = d[31:16];
            2'b01: begin sh_mask[s] = d[31:16]; sh_valid[s] = d[0]; end
            2'b10: sh_ctrl[s] = d[7:0];
            default: ;
         endcase
      end
   endtask

   function automatic int exp_sel(input logic [31:0] a);
      for (int i = 0; i < 7; i++)
         if (sh_valid[i] && (((a[31:16] ^ sh_base[i]) & ~sh_mask[i]) == 16'h0))
            return i;
      return -1;
   endfunction

   function automatic logic [3:0] exp_lanes(input int s, input logic [1:0] sz,
                                            input logic [1:0] a, input bit rd);
      logic [3:0] r;
      int nb, st;
      r = '0;
      if (rd && !sh_ctrl[s][7]) return r;
      case (sh_ctrl[s][1:0])
         2'b01: r = 4'b1000;
         2'b10: begin
            if (sz == 2'b01) r[3 - a[0]] = 1'b1;
            else r = 4'b1100;
         end
         default: begin
            nb = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
            st = (sz == 2'b01) ? int'(a) : (sz == 2'b10) ? 2 * int'(a[1]) : 0;
            for (int k = 0; k < 4; k++)
               if (k >= st && k < st + nb) r[3 - k] = 1'b1;
         end
      endcase
      return r;
   endfunction

   task automatic access(input logic [31:0] a, input bit rd, input logic [1:0] sz,
                         input int extd);
      int s, n;
      bit ok, aa;
      logic [6:0] ecs;
      logic ecoe;
      logic [3:0] ebs;
      s = exp_sel(a);
      ecs  = (s < 0) ? 7'h7F : ~(7'h01 << s);
      ecoe = !(s >= 0 && rd);
      ebs  = (s < 0) ? 4'hF : ~exp_lanes(s, sz, a[1:0], rd);
      @(negedge clk);
      bus_start = 1'b1; bus_addr = a; bus_read = rd; bus_size = sz;
      @(posedge clk);
      #1 bus_start = 1'b0;
      #2;
      chk({cs_n, oe_n, bs_n} === {ecs, ecoe, ebs}, "R1 R2 R6 R9 R10 R11",
          {20'h0, cs_n, oe_n, bs_n}, {20'h0, ecs, ecoe, ebs});
      if (s < 0) begin
         ok = 1'b1;
         repeat (3) begin
            @(posedge clk); #3;
            if (xfer_done !== 1'b0 || cs_n !== 7'h7F) ok = 1'b0;
         end
         chk(ok, "R13 unmatched quiet", {24'h0, xfer_done, cs_n}, {24'h0, 1'b0, 7'h7F});
         return;
      end
      aa = sh_ctrl[s][6];
      n  = aa ? int'(sh_ctrl[s][5:2]) : extd;
      ok = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #3;
         if (cs_n !== ecs || xfer_done !== 1'b0) ok = 1'b0;
      end
      chk(ok, aa ? "R7 hold during waits" : "R8 hold until ack",
          {24'h0, xfer_done, cs_n}, {24'h0, 1'b0, ecs});
      if (!aa) bus_ta_n = 1'b0;
      @(posedge clk);
      #1 bus_ta_n = 1'b1;
      chk(xfer_done === 1'b1 && cs_n === ecs, aa ? "R7 done time" : "R8 done time",
          {24'h0, xfer_done, cs_n}, {24'h0, 1'b1, ecs});
      #2;
      chk(cs_n === 7'h7F && oe_n === 1'b1 && bs_n === 4'hF, "R6 release",
          {20'h0, cs_n, oe_n, bs_n}, {20'h0, 7'h7F, 1'b1, 4'hF});
      @(posedge clk); #1;
      chk(xfer_done === 1'b0, "R7 single pulse", {31'h0, xfer_done}, 32'h0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int unused_seed;
      logic [31:0] a;
      unused_seed = $urandom(32'h5EED_0C5);

      // reset without boot config: pins ignored, 32-bit, 15 waits
      do_reset(1'b0, 2'b01);
      #1;
      chk(cs_n === 7'h7F && oe_n === 1'b1 && bs_n === 4'hF && xfer_done === 1'b0,
          "R3 idle after reset", {19'h0, cs_n, oe_n, bs_n, xfer_done},
          {19'h0, 7'h7F, 1'b1, 4'hF, 1'b0});
      access(32'hDEAD_BEE0, 1'b0, 2'b00, 0);   // R3 R4 R5: select 0 long write
      access(32'h0000_0003, 1'b1, 2'b01, 0);   // R5: read, no strobes in mode 0

      // boot config: 8-bit, then 16-bit
      do_reset(1'b1, 2'b01);
      access(32'h1234_5672, 1'b0, 2'b10, 0);   // R4 8-bit
      do_reset(1'b1, 2'b10);
      access(32'h1234_5671, 1'b0, 2'b01, 0);   // R4 R10 16-bit byte at A0=1
      access(32'h1234_5670, 1'b0, 2'b00, 0);   // R10 16-bit long

      // R3: unprogrammed-but-based select stays inactive
      wreg(3'd3, 2'b00, 32'h8000_0000);
      wreg(3'd3, 2'b10, 32'h0000_0040);
      access(32'h8000_0010, 1'b1, 2'b00, 0);

      // narrow select 0, shorter waits, mode 1
      wreg(3'd0, 2'b01, 32'h0000_0001);
      wreg(3'd0, 2'b00, 32'h0000_0000);
      wreg(3'd0, 2'b10, 32'h0000_00C8);
      access(32'h0000_1002, 1'b1, 2'b10, 0);   // R11 read strobes, R10 word A1=1
      access(32'h0001_0000, 1'b1, 2'b00, 0);   // R13 unmatched

      // R2 overlap: 2 and 5 share a region
      wreg(3'd2, 2'b00, 32'h4000_0000); wreg(3'd2, 2'b01, 32'h000F_0001);
      wreg(3'd2, 2'b10, 32'h0000_0044);
      wreg(3'd5, 2'b00, 32'h4000_0000); wreg(3'd5, 2'b01, 32'h00FF_0001);
      wreg(3'd5, 2'b10, 32'h0000_0001);        // external termination, 8-bit
      access(32'h4003_0001, 1'b0, 2'b01, 0);
      wreg(3'd2, 2'b01, 32'h000F_0000);
      access(32'h4003_0001, 1'b0, 2'b01, 3);   // R8 select 5

      // R12 ignored writes: index 7 and kind 3
      wreg(3'd7, 2'b00, 32'h0000_0000);
      wreg(3'd5, 2'b11, 32'hFFFF_FFFF);
      access(32'h40AB_0000, 1'b1, 2'b00, 1);

      // R13 start during busy ignored
      @(negedge clk);
      bus_start = 1'b1; bus_addr = 32'h0000_0000; bus_read = 1'b0; bus_size = 2'b00;
      @(posedge clk); #1 bus_start = 1'b0;
      @(negedge clk);
      bus_start = 1'b1; bus_addr = 32'h4000_0000;
      @(posedge clk); #1 bus_start = 1'b0;
      repeat (2) @(posedge clk);               // waits = 2: done at third edge
      #3;
      chk(xfer_done === 1'b1, "R13 first access completes", {31'h0, xfer_done}, 32'h1);
      repeat (3) @(posedge clk);
      #3;
      chk(cs_n === 7'h7F && xfer_done === 1'b0, "R13 busy start dropped",
          {24'h0, xfer_done, cs_n}, {24'h0, 1'b0, 7'h7F});

      // random regions and accesses
      for (int r = 0; r < 3; r++) begin
         for (int s = 1; s < 7; s++) begin
            wreg(3'(s), 2'b00, $urandom);
            wreg(3'(s), 2'b01, {16'((1 << ($urandom % 5)) - 1), 15'h0, 1'($urandom % 4 != 0)});
            wreg(3'(s), 2'b10, {24'h0, 2'($urandom), 4'($urandom % 4), 2'($urandom)});
         end
         for (int t = 0; t < 25; t++) begin
            int j;
            j = $urandom % 7;
            a = $urandom;
            if ($urandom % 4 != 0) a[31:16] = sh_base[j] | (16'($urandom) & sh_mask[j]);
            access(a, 1'($urandom), 2'($urandom), $urandom % 4);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule